// File: doc/BRIEF.md
# Mixed-Width Dual-Clock Block RAM

This block is a 4608-bit synchronous memory with one write port and one read port. Each port has its own clock and its own reset. Each port chooses its geometry through a width-select code, and it can change that code on any access. The available shapes are 4Kx1, 2Kx2, 1Kx4, 512x9 and 256x18. Data written at one width can be read back at another, so the block can serve as a bus-width converter between two clock domains.

The storage is organised as 256 rows of 18 bits, and each row is two 9-bit halves. A narrow address picks the row with its upper bits, the half with the next bit, and the slice inside that half with its lowest bits. Packing is little-endian. When a port runs at 1, 2 or 4 bits, the ninth bit of each half plays no part in the data. A narrow write clears the ninth bit of the half it touches, so a later 9-bit read returns a known 0 in that position.

Reads are registered. A mode input adds a second output register, which trades one extra cycle of latency for a shorter path into the logic that follows.

Top module: `mwram_top`

## Requirements
- R1: The width codes are 0 = 4Kx1, 1 = 2Kx2, 2 = 1Kx4, 3 = 512x9 and 4 = 256x18. Codes 5 to 7 behave as 256x18. Read data of width n appears on rd_data[n-1:0], and the bits above are 0.
- R2: Storage bit position. An access at width n and address a lands in row `a >> k`, where k is 4, 3, 2, 1 or 0 for the widths 1, 2, 4, 9 and 18. Within that row the data starts at bit `half*9 + slice*n`. `half` is address bit k-1 (none for 18-bit accesses), and `slice` is made of the address bits below it.
- R3: After an 18-bit write, a 9-bit read at the even address (2r) returns bits [8:0] of row r, and a read at the odd address (2r+1) returns bits [17:9].
- R4: A 9-bit word written at address w can be read as 4-bit words. Address 2w returns bits [3:0] and address 2w+1 returns bits [7:4]. No 4-bit address reaches bit 8.
- R5: A 1-, 2- or 4-bit write clears the ninth bit of the half it writes. A later 9-bit read of that half returns 0 in bit 8.
- R6: A narrow write changes no stored bit except its own slice and that ninth bit.
- R7: With rd_pipe = 0, the data of a read accepted at a rd_clk edge appears after that edge. With rd_pipe = 1, it appears one rd_clk edge later.
- R8: While rd_en is low, rd_data holds its value, even when rd_addr or rd_width change or the same location is written.
- R9: When a read and a write hit the same address on the same clock edge, the read returns the data stored before that write.
- R10: During reset and directly after it, rd_data is 0 in both read modes.
- R11: Address bits above the range of the selected width are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset of the write side; blocks writes while low |
| wr_en | input | 1 | Write strobe |
| wr_width | input | 3 | Write width code (R1) |
| wr_addr | input | 12 | Write address at the selected width |
| wr_data | input | 18 | Write data, right-aligned |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset of the read side |
| rd_en | input | 1 | Read strobe |
| rd_width | input | 3 | Read width code (R1) |
| rd_addr | input | 12 | Read address at the selected width |
| rd_pipe | input | 1 | 1 selects the extra output register |
| rd_data | output | 18 | Read data, right-aligned and zero-padded |

## Verification
The assertions assume the following about the inputs. The width and address codes are known whenever the matching strobe is high. rd_pipe changes only between reads, so the hold property can treat a stable mode as the quiet condition. The stimulus drives every control on the falling edge of its own clock and keeps wr_en and rd_en low between accesses. It switches the read mode only after the previous result has been sampled. Same-address collisions are driven only while the read clock is tied to the write clock, because the old-data rule depends on a shared edge.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

  localparam int HALF_W = 9;
  localparam int WORD_W = 2 * HALF_W;
  localparam int SH_W   = $clog2(WORD_W);

  typedef enum logic [2:0] {
    ASP_1  = 3'd0,
    ASP_2  = 3'd1,
    ASP_4  = 3'd2,
    ASP_9  = 3'd3,
    ASP_18 = 3'd4
  } aspect_e;

  localparam logic [WORD_W-1:0] LANE_1  = WORD_W'(1);
  localparam logic [WORD_W-1:0] LANE_2  = WORD_W'(3);
  localparam logic [WORD_W-1:0] LANE_4  = WORD_W'(15);
  localparam logic [WORD_W-1:0] LANE_9  = WORD_W'({HALF_W{1'b1}});
  localparam logic [WORD_W-1:0] LANE_18 = {WORD_W{1'b1}};

endpackage

// File: rtl/mwram_addr_map.sv
module mwram_addr_map
  import mwram_pkg::*;
#(
  parameter int ROW_AW = 8,
  localparam int AW = ROW_AW + 4
) (
  input  logic [2:0]        width_i,
  input  logic [AW-1:0]     addr_i,
  output logic [ROW_AW-1:0] row_o,
  output logic [SH_W-1:0]   shift_o,
  output logic [WORD_W-1:0] lane_o
);

  logic            half;
  logic [SH_W-1:0] sub;

  // R2 / R11: row from the upper bits, half and slice from the lower ones
  always_comb begin
    case (aspect_e'(width_i))
      ASP_1: begin
        row_o  = addr_i[ROW_AW+3:4];
        half   = addr_i[3];
        sub    = SH_W'(addr_i[2:0]);
        lane_o = LANE_1;
      end
      ASP_2: begin
        row_o  = addr_i[ROW_AW+2:3];
        half   = addr_i[2];
        sub    = SH_W'({addr_i[1:0], 1'b0});
        lane_o = LANE_2;
      end
      ASP_4: begin
        row_o  = addr_i[ROW_AW+1:2];
        half   = addr_i[1];
        sub    = SH_W'({addr_i[0], 2'b00});
        lane_o = LANE_4;
      end
      ASP_9: begin
        row_o  = addr_i[ROW_AW:1];
        half   = addr_i[0];
        sub    = '0;
        lane_o = LANE_9;
      end
      default: begin
        row_o  = addr_i[ROW_AW-1:0];
        half   = 1'b0;
        sub    = '0;
        lane_o = LANE_18;
      end
    endcase
    shift_o = (half ? SH_W'(HALF_W) : '0) + sub;
  end

endmodule

// File: rtl/mwram_store.sv
module mwram_store
  import mwram_pkg::*;
#(
  parameter int ROW_AW = 8,
  localparam int ROWS = 1 << ROW_AW
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [ROW_AW-1:0] wr_row,
  input  logic [SH_W-1:0]   wr_shift,
  input  logic [WORD_W-1:0] wr_lane,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  input  logic [ROW_AW-1:0] rd_row,
  output logic [WORD_W-1:0] rd_word_o
);

  logic [WORD_W-1:0] mem [ROWS];
  logic [WORD_W-1:0] wmask;
  logic [WORD_W-1:0] wval;
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] ninth_bit;
  logic              narrow;
  logic [WORD_W-1:0] rd_word_d;
  logic [WORD_W-1:0] rd_word_q;

  // R5 / R6: a narrow lane also owns the ninth bit of its half, written as 0
  always_comb begin
    narrow    = ~wr_lane[HALF_W-1];
    ninth_bit = (wr_shift >= SH_W'(HALF_W)) ? (WORD_W'(1) << (WORD_W - 1))
                                            : (WORD_W'(1) << (HALF_W - 1));
    wmask     = (wr_lane << wr_shift) | (narrow ? ninth_bit : '0);
    wval      = (wr_data & wr_lane) << wr_shift;
    merged    = (mem[wr_row] & ~wmask) | (wval & wmask);
  end

  always_ff @(posedge wr_clk) begin
    if (wr_en && wr_rst_n) begin
      mem[wr_row] <= merged;
    end
  end

  // R9: the read samples the array before the write of the same edge lands
  always_comb begin
    rd_word_d = rd_en ? mem[rd_row] : rd_word_q;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rd_word_q <= '0;
    end else begin
      rd_word_q <= rd_word_d;
    end
  end

  assign rd_word_o = rd_word_q;

endmodule

// File: rtl/mwram_rd_align.sv
module mwram_rd_align
  import mwram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pipe,
  input  logic [SH_W-1:0]   shift_i,
  input  logic [WORD_W-1:0] lane_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] data_o
);

  logic [SH_W-1:0]   sh_q, sh_d;
  logic [WORD_W-1:0] lane_q, lane_d;
  logic              vld_q, vld_d;
  logic [WORD_W-1:0] s1;
  logic [WORD_W-1:0] s2_q, s2_d;

  // R1: right-align the slice and zero the bits above it
  assign s1 = (word_i >> sh_q) & lane_q;

  always_comb begin
    sh_d   = en ? shift_i : sh_q;
    lane_d = en ? lane_i : lane_q;
    vld_d  = en;
    s2_d   = vld_q ? s1 : s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      lane_q <= '0;
      vld_q  <= 1'b0;
      s2_q   <= '0;
    end else begin
      sh_q   <= sh_d;
      lane_q <= lane_d;
      vld_q  <= vld_d;
      s2_q   <= s2_d;
    end
  end

  // R7: the output register adds one read-clock cycle
  assign data_o = pipe ? s2_q : s1;

endmodule

// File: rtl/mwram_top.sv
module mwram_top
  import mwram_pkg::*;
#(
  parameter int ROW_AW = 8,
  localparam int AW = ROW_AW + 4
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_width,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  input  logic [2:0]        rd_width,
  input  logic [AW-1:0]     rd_addr,
  input  logic              rd_pipe,
  output logic [WORD_W-1:0] rd_data
);

  logic [ROW_AW-1:0] wr_row, rd_row;
  logic [SH_W-1:0]   wr_shift, rd_shift;
  logic [WORD_W-1:0] wr_lane, rd_lane;
  logic [WORD_W-1:0] rd_word;

  mwram_addr_map #(.ROW_AW(ROW_AW)) u_wmap (
    .width_i (wr_width),
    .addr_i  (wr_addr),
    .row_o   (wr_row),
    .shift_o (wr_shift),
    .lane_o  (wr_lane)
  );

  mwram_addr_map #(.ROW_AW(ROW_AW)) u_rmap (
    .width_i (rd_width),
    .addr_i  (rd_addr),
    .row_o   (rd_row),
    .shift_o (rd_shift),
    .lane_o  (rd_lane)
  );

  mwram_store #(.ROW_AW(ROW_AW)) u_store (
    .wr_clk    (wr_clk),
    .wr_rst_n  (wr_rst_n),
    .wr_en     (wr_en),
    .wr_row    (wr_row),
    .wr_shift  (wr_shift),
    .wr_lane   (wr_lane),
    .wr_data   (wr_data),
    .rd_clk    (rd_clk),
    .rd_rst_n  (rd_rst_n),
    .rd_en     (rd_en),
    .rd_row    (rd_row),
    .rd_word_o (rd_word)
  );

  mwram_rd_align u_align (
    .clk     (rd_clk),
    .rst_n   (rd_rst_n),
    .en      (rd_en),
    .pipe    (rd_pipe),
    .shift_i (rd_shift),
    .lane_i  (rd_lane),
    .word_i  (rd_word),
    .data_o  (rd_data)
  );

endmodule

// File: rtl/mwram_chk.sv
module mwram_chk
  import mwram_pkg::*;
#(
  parameter int ROW_AW = 8,
  localparam int AW = ROW_AW + 4
) (
  input logic              wr_clk,
  input logic              wr_rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_width,
  input logic [AW-1:0]     wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic              rd_en,
  input logic [2:0]        rd_width,
  input logic [AW-1:0]     rd_addr,
  input logic              rd_pipe,
  input logic [WORD_W-1:0] rd_data
);

  AST_WR_CTRL_KNOWN: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_en |-> !$isunknown({wr_width, wr_addr}));  // R1

  AST_RD_CTRL_KNOWN: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_en |-> !$isunknown({rd_width, rd_addr, rd_pipe}));  // R1

  AST_NIBBLE_PAD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    ($past(rd_en) && $past(rd_width) == 3'd2 && !rd_pipe) |-> rd_data[WORD_W-1:4] == '0);  // R4

  AST_IDLE_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!$past(rd_en) && !$past(rd_en, 2) && rd_pipe == $past(rd_pipe)) |-> $stable(rd_data));  // R8

  AST_RESET_ZERO: assert property (@(posedge rd_clk)
    !rd_rst_n |-> rd_data == '0);  // R10

endmodule

bind mwram_top mwram_chk #(.ROW_AW(ROW_AW)) u_chk (.*);

// File: tb/sim_mwram_top.sv
`timescale 1ns/1ps
module sim_mwram_top;

  logic        clk, clk_slow, rd_sync, rclk;
  logic        wr_rst_n, rd_rst_n;
  logic        wr_en, rd_en, rd_pipe;
  logic [2:0]  wr_width, rd_width;
  logic [11:0] wr_addr, rd_addr;
  logic [17:0] wr_data, rd_data;
  int          checks, errors;
  logic        ref_bits [0:4607];

  assign rclk = rd_sync ? clk : clk_slow;

  mwram_top u0 (
    .wr_clk(clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_width(wr_width),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(rclk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_width(rd_width),
    .rd_addr(rd_addr), .rd_pipe(rd_pipe), .rd_data(rd_data)
  );

  initial begin clk = 0; forever #2 clk = ~clk; end
  initial begin clk_slow = 0; forever #3.5 clk_slow = ~clk_slow; end

  function automatic int nbits(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 9;
      default: return 18;
    endcase
  endfunction

  // R2 placement rule, R11 upper bits dropped by the masks
  function automatic int bpos(input int code, input int a, input int i);
    int row, half, sub;
    case (code)
      0: begin row = (a >> 4) & 255; half = (a >> 3) & 1; sub = a & 7; end
      1: begin row = (a >> 3) & 255; half = (a >> 2) & 1; sub = (a & 3) * 2; end
      2: begin row = (a >> 2) & 255; half = (a >> 1) & 1; sub = (a & 1) * 4; end
      3: begin row = (a >> 1) & 255; half = a & 1; sub = 0; end
      default: begin row = a & 255; half = 0; sub = 0; end
    endcase
    return row * 18 + half * 9 + sub + i;
  endfunction

  function automatic logic [17:0] exp_rd(input int code, input int a);
    logic [17:0] r;
    r = '0;
    for (int i = 0; i < nbits(code); i++) r[i] = ref_bits[bpos(code, a, i)];
    return r;
  endfunction

  task automatic chk(input string req, input logic [17:0] got, input logic [17:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_wr(input int code, input int a, input logic [17:0] d);
    int p;
    for (int i = 0; i < nbits(code); i++) ref_bits[bpos(code, a, i)] = d[i];
    if (nbits(code) < 9) begin
      p = bpos(code, a, 0);
      ref_bits[(p / 9) * 9 + 8] = 1'b0;
    end
  endtask

  task automatic wr(input int code, input int a, input logic [17:0] d);
    @(negedge clk);
    wr_en = 1; wr_width = code[2:0]; wr_addr = a[11:0]; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    model_wr(code, a, d);
  endtask

  task automatic rd(input int code, input int a, input logic pipe,
                    output logic [17:0] got, output logic [17:0] early);
    @(negedge rclk);
    rd_en = 1; rd_width = code[2:0]; rd_addr = a[11:0]; rd_pipe = pipe;
    @(negedge rclk);
    rd_en = 0;
    early = rd_data;
    if (pipe) @(negedge rclk);
    got = rd_data;
  endtask

  task automatic rd_chk(input string req, input int code, input int a);
    logic [17:0] g, e;
    rd(code, a, 1'b0, g, e);
    chk(req, g, exp_rd(code, a));
  endtask

  task automatic t_reset;
    chk("R10 nonpipe", rd_data, 18'h0);
    @(negedge rclk); rd_pipe = 1;
    #0.1 chk("R10 pipe", rd_data, 18'h0);
    rd_pipe = 0;
  endtask

  task automatic t_fill;
    for (int r = 0; r < 256; r++) wr(4, r, 18'h0);
  endtask

  task automatic t_same_addr;
    logic [17:0] g;
    wr(4, 10, 18'h2AAAA);
    @(negedge clk);
    wr_en = 1; wr_width = 3'd4; wr_addr = 12'd10; wr_data = 18'h15555;
    rd_en = 1; rd_width = 3'd4; rd_addr = 12'd10; rd_pipe = 0;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    g = rd_data;
    model_wr(4, 10, 18'h15555);
    chk("R9 old data", g, 18'h2AAAA);
    rd_chk("R9 new data after", 4, 10);
  endtask

  task automatic t_wide;
    wr(4, 0, 18'h3FFFF); wr(4, 1, 18'h12345); wr(4, 255, 18'h2DB6D);
    rd_chk("R2 row0", 4, 0);
    rd_chk("R2 row1", 4, 1);
    rd_chk("R2 row255", 4, 255);
    wr(3, 5, 18'h0AB);
    rd_chk("R2 9bit into upper half", 4, 2);
  endtask

  task automatic t_w18_r9;
    logic [17:0] g, e;
    wr(4, 20, 18'h3C0A5);
    rd(3, 40, 1'b0, g, e); chk("R3 even half", g, 18'h000A5);
    rd(3, 41, 1'b0, g, e); chk("R3 odd half", g, 18'h001E0);
  endtask

  task automatic t_w9_r4;
    logic [17:0] g, e;
    wr(3, 100, 18'h1A5);
    rd(2, 200, 1'b0, g, e); chk("R4 low nibble", g, 18'h5);
    rd(2, 201, 1'b0, g, e); chk("R4 high nibble", g, 18'hA);
    rd(2, 202, 1'b0, g, e); chk("R4 next half, bit8 unreachable", g, exp_rd(2, 202));
  endtask

  task automatic t_w4_r9;
    logic [17:0] g, e;
    wr(3, 60, 18'h1FF);
    wr(2, 120, 18'h3);
    rd(3, 60, 1'b0, g, e); chk("R5 ninth bit cleared", g, 18'h0F3);
  endtask

  task automatic t_keep;
    logic [17:0] g, e;
    wr(4, 70, 18'h3FFFF);
    wr(0, 70 * 16 + 5, 18'h0);
    rd(4, 70, 1'b0, g, e); chk("R6 one bit cleared", g, 18'h3FEDF);
    wr(1, 70 * 8 + 6, 18'h1);
    rd_chk("R6 2bit in upper half", 4, 70);
  endtask

  task automatic t_mix;
    for (int i = 0; i < 16; i++) wr(1, 800 + i, 18'(i * 3));
    for (int i = 0; i < 32; i++) rd_chk("R2 2bit write 1bit read", 0, 1600 + i);
    rd_chk("R1 2bit read pad", 1, 805);
  endtask

  task automatic t_pipe;
    logic [17:0] g, e, prev;
    wr(4, 90, 18'h0BEEF);
    wr(4, 91, 18'h31337);
    rd_chk("R7 prime", 4, 90);
    @(negedge rclk); rd_pipe = 1;
    rd(4, 90, 1'b1, g, e);
    prev = g;
    rd(4, 91, 1'b1, g, e);
    chk("R7 pipe one edge old", e, prev);
    chk("R7 pipe second edge new", g, exp_rd(4, 91));
    @(negedge rclk); rd_pipe = 0;
    rd(2, 91 * 4 + 1, 1'b0, g, e);
    chk("R7 nonpipe first edge", e, exp_rd(2, 91 * 4 + 1));
  endtask

  task automatic t_hold;
    logic [17:0] keep;
    rd_chk("R8 setup", 4, 1);
    keep = rd_data;
    @(negedge rclk); rd_addr = 12'd90; rd_width = 3'd3;
    wr(4, 1, 18'h00F0F);
    repeat (4) @(negedge rclk);
    chk("R8 hold while idle", rd_data, keep);
  endtask

  task automatic t_upper;
    wr(4, 12'hF05, 18'h2468A);
    rd_chk("R11 18bit upper ignored", 4, 5);
    rd_chk("R11 9bit upper ignored", 3, 12'hE0A);
  endtask

  task automatic t_codes;
    wr(5, 33, 18'h1B3C5);
    rd_chk("R1 code5 as 18", 6, 33);
    rd_chk("R1 code4 read", 4, 33);
  endtask

  initial begin
    checks = 0; errors = 0;
    wr_rst_n = 0; rd_rst_n = 0; rd_sync = 1;
    wr_en = 0; rd_en = 0; rd_pipe = 0;
    wr_width = 0; rd_width = 0; wr_addr = 0; rd_addr = 0; wr_data = 0;
    for (int i = 0; i < 4608; i++) ref_bits[i] = 1'b0;
    repeat (5) @(negedge clk);
    wr_rst_n = 1; rd_rst_n = 1;
    @(negedge clk);
    t_reset;
    t_fill;
    t_same_addr;
    @(negedge clk); rd_sync = 0;
    t_wide;
    t_w18_r9;
    t_w9_r4;
    t_w4_r9;
    t_keep;
    t_mix;
    t_pipe;
    t_hold;
    t_upper;
    t_codes;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired got hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule